// File: doc/BRIEF.md
# Two-Segment Frequency Ramp Sequencer

This block produces a digital frequency ramp for a fractional-N synthesiser. It adds a signed step to a 30-bit accumulator once per phase-detector clock and alternates between two programmed ramp segments. Each segment has its own settings:

- the step value;
- a length in steps;
- a half-rate option that doubles its duration;
- the segment that follows it;
- the condition that ends it: length expiry, a rising edge on trigger input A, a rising edge on trigger input B, or never.

The configuration is presented as parallel fields and is read live on every clock. The outputs are the accumulator value, which a downstream modulator consumes, and the index of the active segment. An option can clear the accumulator each time segment 1 is entered, so that rounding error cannot build up over many ramp cycles. A manual mode leaves sequencing to the trigger inputs alone.

Top module: `ramp_seq`

## Requirements
- R1: While `rst` is high, and on every clock where `enable` is low, the block returns after the next clock edge to segment 0 (`seg_idx`=0) with `ramp_val`=0.
- R2: On each stepping clock, `ramp_val` becomes the previous value plus the active segment's 30-bit two's-complement step, taken modulo 2^30. Without the half-rate option, every enabled clock is a stepping clock.
- R3: In automatic mode (`manual_mode`=0) with advance code 0, a segment ends on its Nth stepping clock, where N is its length field and a length of 0 acts as 1. That clock still applies the old segment's step. From the following clock, the successor segment's step is used.
- R4: With a segment's half-rate bit set, only every second clock in that segment is a stepping clock, starting with the second clock after the segment is entered, so its duration doubles.
- R5: A segment's successor bit selects the next segment (0 = segment 0, 1 = segment 1), and a segment may follow itself.
- R6: Advance code 1 ends the segment on a rising edge of `trig_a`, and code 2 on a rising edge of `trig_b`. The segment changes at the third rising clock edge after the input rises. A trigger held high causes only one advance.
- R7: Advance code 3 never ends the segment: the segment index stays where it is and stepping continues.
- R8: In automatic mode with `seg1_clr`=1, each entry into segment 1 forces `ramp_val` to 0 on that clock, and the step of that clock is discarded.
- R9: In manual mode (`manual_mode`=1), length expiry ends no segment and `seg1_clr` has no effect. Trigger advances (codes 1 and 2) still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Ramp run enable; low holds the initial state |
| manual_mode | input | 1 | 0 automatic, 1 manual (trigger-only sequencing) |
| seg1_clr | input | 1 | Clear accumulator on entry to segment 1 (automatic mode) |
| seg0_inc | input | 30 | Segment 0 step, two's complement |
| seg0_len | input | 16 | Segment 0 length in steps |
| seg0_half | input | 1 | Segment 0 half-rate option |
| seg0_next | input | 1 | Segment following segment 0 |
| seg0_adv | input | 2 | Segment 0 advance code (0 length, 1 A, 2 B, 3 never) |
| seg1_inc | input | 30 | Segment 1 step, two's complement |
| seg1_len | input | 16 | Segment 1 length in steps |
| seg1_half | input | 1 | Segment 1 half-rate option |
| seg1_next | input | 1 | Segment following segment 1 |
| seg1_adv | input | 2 | Segment 1 advance code (0 length, 1 A, 2 B, 3 never) |
| trig_a | input | 1 | Asynchronous trigger input A |
| trig_b | input | 1 | Asynchronous trigger input B |
| ramp_val | output | 30 | Accumulator value |
| seg_idx | output | 1 | Active segment index |

## Verification
Both outputs are registered, so the result of a step, an advance or a clear appears one clock edge after the clock on which its condition holds. A trigger input needs three edges: two synchroniser stages and the edge register. The bench drives inputs on the falling edge and advances a behavioural model on each rising edge. The model keeps the trigger history in a queue and takes an edge as the sample from two clocks back being high while the sample from three clocks back was low. The outputs are compared with the model at every falling edge, and directed checks fix the exact edge on which a trigger takes effect.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
    localparam int ACC_W = 30;
    localparam int LEN_W = 16;
    localparam int NSEG  = 2;
    localparam int SEG_W = $clog2(NSEG);
    localparam int NTRIG = 2;

    typedef enum logic [1:0] {
        ADV_LEN    = 2'd0,
        ADV_TRIG_A = 2'd1,
        ADV_TRIG_B = 2'd2,
        ADV_NEVER  = 2'd3
    } adv_src_e;

    typedef struct packed {
        logic [ACC_W-1:0] inc;
        logic [LEN_W-1:0] len;
        logic             half;
        logic [SEG_W-1:0] succ;
        adv_src_e         adv;
    } seg_cfg_t;

    // True when one more step reaches the length (length 0 acts as 1).
    function automatic logic len_reached(logic [LEN_W-1:0] cnt, logic [LEN_W-1:0] len);
        return ({1'b0, cnt} + 1'b1) >= {1'b0, len};
    endfunction

    function automatic logic [LEN_W-1:0] sat_step(logic [LEN_W-1:0] cnt);
        return (&cnt) ? cnt : cnt + 1'b1;
    endfunction
endpackage

// File: rtl/ramp_trig_sync.sv
module ramp_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sr;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr   <= '0;
            last <= 1'b0;
        end else begin
            sr   <= {sr[STAGES-2:0], din};
            last <= sr[STAGES-1];
        end
    end

    assign rise = sr[STAGES-1] & ~last;
endmodule

// File: rtl/ramp_seg_ctrl.sv
module ramp_seg_ctrl
    import ramp_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   enable,
    input  logic                   manual_mode,
    input  logic                   clr_opt,
    input  seg_cfg_t               cfg [NSEG],
    input  logic [NTRIG-1:0]       trig_rise,
    output logic [SEG_W-1:0]       seg,
    output logic                   tick,
    output logic                   clr_acc,
    output logic [ACC_W-1:0]       step_inc
);
    seg_cfg_t         cur;
    logic [LEN_W-1:0] cnt;
    logic             phase;
    logic             timeout, hit, adv;

    always_comb begin
        cur      = cfg[seg];
        tick     = ~cur.half | phase;
        step_inc = cur.inc;
        timeout  = ~manual_mode && (cur.adv == ADV_LEN) && tick && len_reached(cnt, cur.len);
        hit      = ((cur.adv == ADV_TRIG_A) && trig_rise[0]) ||
                   ((cur.adv == ADV_TRIG_B) && trig_rise[1]);
        adv      = timeout | hit;
        clr_acc  = adv && (cur.succ == SEG_W'(1)) && clr_opt && ~manual_mode;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            seg   <= '0;
            cnt   <= '0;
            phase <= 1'b0;
        end else if (adv) begin
            seg   <= cur.succ;
            cnt   <= '0;
            phase <= 1'b0;
        end else begin
            if (tick) cnt <= sat_step(cnt);
            phase <= cur.half ? ~phase : 1'b0;
        end
    end
endmodule

// File: rtl/ramp_accum.sv
module ramp_accum
    import ramp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             tick,
    input  logic             clr,
    input  logic [ACC_W-1:0] inc,
    output logic [ACC_W-1:0] acc
);
    always_ff @(posedge clk) begin
        if (rst || !enable) acc <= '0;
        else if (clr)       acc <= '0;
        else if (tick)      acc <= acc + inc;
    end
endmodule

// File: rtl/ramp_seq.sv
module ramp_seq
    import ramp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              manual_mode,
    input  logic              seg1_clr,
    input  logic [ACC_W-1:0]  seg0_inc,
    input  logic [LEN_W-1:0]  seg0_len,
    input  logic              seg0_half,
    input  logic              seg0_next,
    input  logic [1:0]        seg0_adv,
    input  logic [ACC_W-1:0]  seg1_inc,
    input  logic [LEN_W-1:0]  seg1_len,
    input  logic              seg1_half,
    input  logic              seg1_next,
    input  logic [1:0]        seg1_adv,
    input  logic              trig_a,
    input  logic              trig_b,
    output logic [ACC_W-1:0]  ramp_val,
    output logic              seg_idx
);
    seg_cfg_t         cfg [NSEG];
    logic [NTRIG-1:0] trig_in, trig_rise;
    logic [SEG_W-1:0] seg;
    logic             tick, clr_acc;
    logic [ACC_W-1:0] step_inc;

    always_comb begin
        cfg[0] = '{inc: seg0_inc, len: seg0_len, half: seg0_half,
                   succ: SEG_W'(seg0_next), adv: adv_src_e'(seg0_adv)};
        cfg[1] = '{inc: seg1_inc, len: seg1_len, half: seg1_half,
                   succ: SEG_W'(seg1_next), adv: adv_src_e'(seg1_adv)};
    end

    assign trig_in = {trig_b, trig_a};

    for (genvar t = 0; t < NTRIG; t++) begin : g_trig
        ramp_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .din (trig_in[t]),
            .rise(trig_rise[t])
        );
    end

    ramp_seg_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .manual_mode(manual_mode),
        .clr_opt    (seg1_clr),
        .cfg        (cfg),
        .trig_rise  (trig_rise),
        .seg        (seg),
        .tick       (tick),
        .clr_acc    (clr_acc),
        .step_inc   (step_inc)
    );

    ramp_accum u_acc (
        .clk   (clk),
        .rst   (rst),
        .enable(enable),
        .tick  (tick),
        .clr   (clr_acc),
        .inc   (step_inc),
        .acc   (ramp_val)
    );

    assign seg_idx = seg[0];
endmodule

// File: rtl/ramp_seq_chk.sv
module ramp_seq_chk
    import ramp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic              manual_mode,
    input logic              seg1_clr,
    input logic [ACC_W-1:0]  seg0_inc,
    input logic              seg0_half,
    input logic              seg0_next,
    input logic [1:0]        seg0_adv,
    input logic [1:0]        seg1_adv,
    input logic [ACC_W-1:0]  ramp_val,
    input logic              seg_idx
);
    AST_IDLE_STATE: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (ramp_val == '0 && !seg_idx)); // R1

    AST_SEG0_STEP: assert property (@(posedge clk) disable iff (rst)
        (enable && !seg_idx && !seg0_half && !(seg0_next && seg1_clr && !manual_mode))
        |=> ramp_val == $past(ramp_val + seg0_inc)); // R2

    AST_NEVER_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (enable && !seg_idx && seg0_adv == 2'd3) |=> !seg_idx); // R7

    AST_CLR_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (enable && !manual_mode && seg1_clr && !seg_idx && seg0_next)
        |=> (!seg_idx || ramp_val == '0)); // R8

    AST_MANUAL_NO_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        (enable && manual_mode && seg_idx && seg1_adv == 2'd0) |=> seg_idx); // R9
endmodule

bind ramp_seq ramp_seq_chk u_chk (.*);

// File: tb/tb_ramp_seq.sv
module tb_ramp_seq;
    localparam longint MASK = (64'd1 << 30) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0, manual_mode = 1'b0, seg1_clr = 1'b0;
    logic [29:0] seg0_inc = '0, seg1_inc = '0;
    logic [15:0] seg0_len = '0, seg1_len = '0;
    logic        seg0_half = 1'b0, seg1_half = 1'b0, seg0_next = 1'b0, seg1_next = 1'b0;
    logic [1:0]  seg0_adv = '0, seg1_adv = '0;
    logic        trig_a = 1'b0, trig_b = 1'b0;
    logic [29:0] ramp_val;
    logic        seg_idx;

    int total = 0, bad = 0, cycles = 0;
    string req = "R1";
    bit done = 1'b0;

    ramp_seq dut (.*);

    always #10 clk = ~clk;

    // behavioural reference
    longint macc = 0;
    int     mcnt = 0;
    bit     mseg = 0, mph = 0;
    bit     qa[$], qb[$];

    initial begin
        qa = '{0, 0, 0};
        qb = '{0, 0, 0};
    end

    always @(posedge clk) begin
        longint inc, step;
        int len;
        bit half, nxt, tick, pa, pb, adv;
        logic [1:0] code;
        pa = qa[1] && !qa[2];
        pb = qb[1] && !qb[2];
        if (rst) begin
            qa = '{0, 0, 0};
            qb = '{0, 0, 0};
        end else begin
            qa.push_front(trig_a); void'(qa.pop_back());
            qb.push_front(trig_b); void'(qb.pop_back());
        end
        inc  = mseg ? longint'(seg1_inc) : longint'(seg0_inc);
        len  = mseg ? int'(seg1_len) : int'(seg0_len);
        half = mseg ? seg1_half : seg0_half;
        nxt  = mseg ? seg1_next : seg0_next;
        code = mseg ? seg1_adv : seg0_adv;
        if (len == 0) len = 1;
        if (rst || !enable) begin
            mseg = 0; macc = 0; mcnt = 0; mph = 0;
        end else begin
            tick = !half || mph;
            adv  = (!manual_mode && code == 2'd0 && tick && mcnt + 1 >= len) ||
                   (code == 2'd1 && pa) || (code == 2'd2 && pb);
            step = tick ? ((macc + inc) & MASK) : macc;
            if (adv) begin
                macc = (nxt && seg1_clr && !manual_mode) ? 0 : step;
                mseg = nxt; mcnt = 0; mph = 0;
            end else begin
                macc = step;
                if (tick && mcnt < 65535) mcnt++;
                mph = half ? !mph : 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            total++;
            if (ramp_val !== 30'(macc) || seg_idx !== mseg) begin
                bad++;
                $display("FAIL %s: ramp=%h seg=%0d expected ramp=%h seg=%0d",
                         req, ramp_val, seg_idx, 30'(macc), mseg);
            end
        end
    end

    task automatic check(string r, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restart();
        @(negedge clk); enable = 1'b0;
        @(negedge clk); enable = 1'b1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<=200000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        run(3);
        @(negedge clk); rst = 1'b0;
        check("R1 reset ramp", ramp_val, 0);
        check("R1 reset seg", seg_idx, 0);

        // R2 R3: length-timed alternation, wrapping step
        req = "R2/R3";
        seg0_inc = 30'h1FFFFFFF; seg0_len = 16'd4; seg0_next = 1'b1;
        seg1_inc = 30'(-3);      seg1_len = 16'd3; seg1_next = 1'b0;
        enable = 1'b1;
        run(60);
        req = "R3 len0";
        seg1_len = 16'd0;
        run(20);

        req = "R4";
        seg0_half = 1'b1; seg1_len = 16'd2;
        restart();
        run(60);
        seg1_half = 1'b1;
        run(40);
        seg0_half = 1'b0; seg1_half = 1'b0;

        req = "R5";
        seg0_next = 1'b0;
        restart();
        run(40);
        check("R5 self-repeat seg", seg_idx, 0);
        seg0_next = 1'b1; seg1_next = 1'b1;
        run(40);
        check("R5 seg1 repeat", seg_idx, 1);
        seg1_next = 1'b0;

        req = "R8";
        seg1_clr = 1'b1;
        restart();
        run(60);

        req = "R6";
        seg1_clr = 1'b0; seg0_adv = 2'd1; seg1_adv = 2'd2;
        restart();
        run(5);
        trig_a = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R6 before third edge", seg_idx, 0);
        @(negedge clk);
        check("R6 at third edge", seg_idx, 1);
        run(10);
        trig_b = 1'b1; run(10);
        check("R6 held trigger single advance", seg_idx, 0);
        trig_a = 1'b0; trig_b = 1'b0; run(5);
        trig_a = 1'b1; run(1); trig_a = 1'b0; run(8);
        trig_b = 1'b1; run(1); trig_b = 1'b0; run(8);

        req = "R7";
        seg0_adv = 2'd3;
        restart();
        trig_a = 1'b1; run(5); trig_a = 1'b0; run(30);
        check("R7 never advance", seg_idx, 0);

        req = "R9";
        manual_mode = 1'b1; seg1_clr = 1'b1;
        seg0_adv = 2'd0; seg0_len = 16'd1;
        restart();
        run(30);
        check("R9 no timeout in manual", seg_idx, 0);
        seg0_adv = 2'd1; seg1_adv = 2'd0;
        trig_a = 1'b1; run(6); trig_a = 1'b0;
        check("R9 trigger still advances", seg_idx, 1);
        check("R9 no clear on entry", (ramp_val == 0) ? 1 : 0, 0);
        run(30);
        check("R9 seg1 held", seg_idx, 1);

        req = "R1 disable";
        manual_mode = 1'b0; seg0_adv = 2'd0; seg1_adv = 2'd0; seg0_len = 16'd5;
        run(20);
        enable = 1'b0;
        @(negedge clk);
        check("R1 disable ramp", ramp_val, 0);
        check("R1 disable seg", seg_idx, 0);
        enable = 1'b1;
        run(20);
        finish_run();
    end
endmodule